// File: doc/BRIEF.md
# Dual-Output Interrupt Controller

This block gathers interrupt requests from on-chip peripherals and from board-level pins and hands them to a single processor core through two request lines. One line is for critical events and the other is for ordinary events. For each source, software chooses the detection style (sticky edge capture or live level), the active sense (high/rising or low/falling), the output line it drives, and whether it is enabled. Among the critical sources that are enabled and pending, a programmable rank picks one winner. The block then publishes a vector address for that winner, so the handler can branch to it without searching.

Software reaches the block through a 32-bit register port. A request is accepted on every cycle on which `reg_req` is high, so the port never back-pressures. A write takes effect at the clock edge that samples it. Read data and `reg_rvalid` appear one cycle after the read request. The sources are numbered with the external pins first (indices 0 to 6) and the internal lines after them (indices 7 to 25). All source inputs are assumed to be synchronous to `clk` already.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, every register reads zero, `crit_irq`, `ncrit_irq` and `reg_rvalid` are low, and `crit_vector` is zero. With zero in the polarity register, every source is active-high; with zero in the trigger register, every source is level-sensitive; with zero in the route register, every source is non-critical.
- R2: A level-mode source has a status bit equal to its input XOR its polarity bit (1 = active-low). The status bit reflects the input one cycle after that input is sampled.
- R3: An edge-mode source (trigger bit 1) sets a sticky status bit when its input changes toward the active sense. With polarity 0 this is a rising edge; with polarity 1 it is a falling edge. A change in the opposite direction leaves the bit unchanged, and the bit stays set after the input returns to idle.
- R4: Writing address 0 (RAW) clears each edge-mode status bit whose write-data bit is 1. A 0 in the write data leaves that status bit as it is. If an edge is detected in the same cycle as the clearing write, the status bit stays set.
- R5: The masked status (address 2) equals the raw status AND the enable register. A source whose enable bit is 0 never raises either output.
- R6: `crit_irq` is high when any source that is enabled, pending and marked critical (route bit 1) exists. `ncrit_irq` is high when any source that is enabled, pending and marked non-critical exists.
- R7: Each source has a 4-bit rank. Among the enabled, pending critical sources, the one with the numerically lowest rank wins. When two sources have equal ranks, the lower source index wins. Non-critical sources never take part in this choice.
- R8: `crit_vector` and the read-only VEC register (address 7) equal the base register plus the winner's index shifted left by 2. When no critical source is pending, both equal the base register. Both update one cycle after the status bits change.
- R9: The register addresses are: 0 RAW, 1 ENABLE, 2 MASKED (read-only), 3 POLARITY, 4 TRIGGER, 5 ROUTE, 6 BASE (32-bit), 7 VEC (read-only), and 8 to 11 RANK. RANK word k holds source 8k+s in bits [4s+3:4s]. Writes to read-only addresses are ignored, and a read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_ext | input | 7 | External pin requests, source indices 0 to 6 |
| irq_int | input | 19 | Internal peripheral requests, source indices 7 to 25 |
| reg_req | input | 1 | Register access request, accepted in every cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid together with `reg_rvalid` |
| reg_rvalid | output | 1 | High one cycle after a read request |
| crit_irq | output | 1 | Critical request to the core |
| ncrit_irq | output | 1 | Non-critical request to the core |
| crit_vector | output | 32 | Vector address of the winning critical source |

## Verification
The assertions assume that every source input is already synchronous to `clk` and changes only between clock edges. They also assume that a register access lasts exactly one cycle. The level-tracking and vector checks are held off for the first cycle after reset, because the flops have not yet captured their inputs then. The stimulus drives the sources and the register port only just after the falling clock edge. It keeps each access as a one-cycle pulse of `reg_req`, and it holds the inputs at their idle level while reset is applied.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 4;

  typedef logic [ADDR_W-1:0] reg_addr_t;

  localparam reg_addr_t A_RAW   = 4'd0;
  localparam reg_addr_t A_EN    = 4'd1;
  localparam reg_addr_t A_MSK   = 4'd2;
  localparam reg_addr_t A_POL   = 4'd3;
  localparam reg_addr_t A_TRG   = 4'd4;
  localparam reg_addr_t A_ROUTE = 4'd5;
  localparam reg_addr_t A_BASE  = 4'd6;
  localparam reg_addr_t A_VEC   = 4'd7;
  localparam reg_addr_t A_RANK0 = 4'd8;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src_in,
  input  logic pol,
  input  logic edge_mode,
  input  logic clr,
  output logic stat_o
);
  logic prev_q, stat_q, stat_d, armed_q;
  logic corr, hit;

  // polarity-corrected input; edge means corrected value went 0 -> 1
  assign corr = src_in ^ pol;
  assign hit  = edge_mode & corr & ~(prev_q ^ pol);

  always_comb begin
    if (!edge_mode)  stat_d = corr;
    else if (hit)    stat_d = 1'b1;
    else if (clr)    stat_d = 1'b0;
    else             stat_d = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      stat_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= src_in;
      stat_q  <= stat_d;
      armed_q <= 1'b1;
    end
  end

  assign stat_o = stat_q;

  p_level_track_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $past(!edge_mode) |-> (stat_q == $past(src_in ^ pol)))
    else $error("level status lost track of input");

  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && stat_q && !clr) |=> stat_q)
    else $error("edge status dropped without clear");

  p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && clr && !hit) |=> !stat_q)
    else $error("edge status not cleared");

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stat_q)
    else $error("detected edge not captured");
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_SRC  = 26,
  parameter int unsigned RANK_W = 4,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        pend,
  input  logic [N_SRC*RANK_W-1:0] rank,
  output logic                    any_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [RANK_W-1:0] best_rank;
  logic [IDX_W-1:0]  best_idx;
  logic              found;

  // strict less-than keeps the earlier (lower index) source on a tie
  always_comb begin
    best_rank = '1;
    best_idx  = '0;
    found     = 1'b0;
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (pend[i] && (!found || rank[i*RANK_W +: RANK_W] < best_rank)) begin
        found     = 1'b1;
        best_rank = rank[i*RANK_W +: RANK_W];
        best_idx  = IDX_W'(i);
      end
    end
  end

  assign any_o = found;
  assign idx_o = best_idx;

  logic [RANK_W-1:0] win_rank;
  assign win_rank = rank[idx_o*RANK_W +: RANK_W];

  for (genvar j = 0; j < N_SRC; j++) begin : g_chk
    p_rank_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend[j] |-> (any_o && pend[idx_o] && rank[j*RANK_W +: RANK_W] >= win_rank))
      else $error("winner does not hold lowest rank");

    p_tie_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[j] && rank[j*RANK_W +: RANK_W] == win_rank) |-> (32'(idx_o) <= j))
      else $error("tie not resolved to lower index");
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC  = 26,
  parameter int unsigned RANK_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_req,
  input  logic                    reg_wr,
  input  reg_addr_t               reg_addr,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  output logic                    reg_rvalid,
  input  logic [N_SRC-1:0]        raw_stat,
  input  logic [REG_W-1:0]        vec_in,
  output logic [N_SRC-1:0]        en_o,
  output logic [N_SRC-1:0]        pol_o,
  output logic [N_SRC-1:0]        trg_o,
  output logic [N_SRC-1:0]        route_o,
  output logic [REG_W-1:0]        base_o,
  output logic [N_SRC*RANK_W-1:0] rank_o,
  output logic [N_SRC-1:0]        clr_o
);
  localparam int unsigned RPW        = REG_W / RANK_W;
  localparam int unsigned RANK_WORDS = (N_SRC + RPW - 1) / RPW;

  logic [N_SRC-1:0]        en_q, pol_q, trg_q, route_q;
  logic [REG_W-1:0]        base_q;
  logic [N_SRC*RANK_W-1:0] rank_q;
  logic [REG_W-1:0]        rdata_q, rd_word;
  logic                    rvalid_q;
  logic                    wr_hit, rd_hit;
  logic [REG_W-1:0]        rank_word [RANK_WORDS];

  assign wr_hit = reg_req & reg_wr;
  assign rd_hit = reg_req & ~reg_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pol_q   <= '0;
      trg_q   <= '0;
      route_q <= '0;
      base_q  <= '0;
    end else if (wr_hit) begin
      case (reg_addr)
        A_EN:    en_q    <= reg_wdata[N_SRC-1:0];
        A_POL:   pol_q   <= reg_wdata[N_SRC-1:0];
        A_TRG:   trg_q   <= reg_wdata[N_SRC-1:0];
        A_ROUTE: route_q <= reg_wdata[N_SRC-1:0];
        A_BASE:  base_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_q <= '0;
    end else begin
      for (int i = 0; i < int'(N_SRC); i++) begin
        if (wr_hit && reg_addr == ADDR_W'(int'(A_RANK0) + i / int'(RPW)))
          rank_q[i*RANK_W +: RANK_W] <= reg_wdata[(i % int'(RPW))*RANK_W +: RANK_W];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < int'(RANK_WORDS); k++) begin
      rank_word[k] = '0;
      for (int s = 0; s < int'(RPW); s++) begin
        if (k * int'(RPW) + s < int'(N_SRC))
          rank_word[k][s*RANK_W +: RANK_W] = rank_q[(k*int'(RPW)+s)*RANK_W +: RANK_W];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    case (reg_addr)
      A_RAW:   rd_word = REG_W'(raw_stat);
      A_EN:    rd_word = REG_W'(en_q);
      A_MSK:   rd_word = REG_W'(raw_stat & en_q);
      A_POL:   rd_word = REG_W'(pol_q);
      A_TRG:   rd_word = REG_W'(trg_q);
      A_ROUTE: rd_word = REG_W'(route_q);
      A_BASE:  rd_word = base_q;
      A_VEC:   rd_word = vec_in;
      default: begin
        for (int k = 0; k < int'(RANK_WORDS); k++)
          if (reg_addr == ADDR_W'(int'(A_RANK0) + k)) rd_word = rank_word[k];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_hit;
      if (rd_hit) rdata_q <= rd_word;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;
  assign en_o       = en_q;
  assign pol_o      = pol_q;
  assign trg_o      = trg_q;
  assign route_o    = route_q;
  assign base_o     = base_q;
  assign rank_o     = rank_q;
  assign clr_o      = (wr_hit && reg_addr == A_RAW) ? reg_wdata[N_SRC-1:0] : '0;

  p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> reg_rvalid)
    else $error("read data not returned next cycle");

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> !reg_rvalid)
    else $error("rvalid without read request");
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_EXT     = 7,
  parameter int unsigned N_INT     = 19,
  parameter int unsigned RANK_W    = 4,
  parameter int unsigned VEC_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  irq_ext,
  input  logic [N_INT-1:0]  irq_int,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              reg_rvalid,
  output logic              crit_irq,
  output logic              ncrit_irq,
  output logic [REG_W-1:0]  crit_vector
);
  localparam int unsigned N_SRC = N_EXT + N_INT;
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0]        src_vec, stat, clr;
  logic [N_SRC-1:0]        en, pol, trg, route;
  logic [N_SRC-1:0]        masked, crit_pend, ncrit_pend;
  logic [N_SRC*RANK_W-1:0] rank;
  logic [REG_W-1:0]        base, vec_q;
  logic                    win_any, armed_q;
  logic [IDX_W-1:0]        win_idx;

  assign src_vec = {irq_int, irq_ext};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    irq_src_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_in    (src_vec[g]),
      .pol       (pol[g]),
      .edge_mode (trg[g]),
      .clr       (clr[g]),
      .stat_o    (stat[g])
    );
  end

  irq_regfile #(.N_SRC(N_SRC), .RANK_W(RANK_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_req    (reg_req),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .raw_stat   (stat),
    .vec_in     (vec_q),
    .en_o       (en),
    .pol_o      (pol),
    .trg_o      (trg),
    .route_o    (route),
    .base_o     (base),
    .rank_o     (rank),
    .clr_o      (clr)
  );

  assign masked     = stat & en;
  assign crit_pend  = masked & route;
  assign ncrit_pend = masked & ~route;

  irq_prio_pick #(.N_SRC(N_SRC), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (crit_pend),
    .rank  (rank),
    .any_o (win_any),
    .idx_o (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      vec_q   <= win_any ? base + (REG_W'(win_idx) << VEC_SHIFT) : base;
      armed_q <= 1'b1;
    end
  end

  assign crit_irq    = |crit_pend;
  assign ncrit_irq   = |ncrit_pend;
  assign crit_vector = vec_q;

  p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $past(!win_any) |-> (crit_vector == $past(base)))
    else $error("idle vector differs from base");

  p_mask_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (!crit_irq && !ncrit_irq))
    else $error("output raised with all sources disabled");
endmodule

// File: tb/test_irq_ctrl_top.sv
module test_irq_ctrl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] src = '0;
  logic        reg_req = 1'b0, reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, crit_vector;
  logic        reg_rvalid, crit_irq, ncrit_irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] rk [4];

  always #2.5 clk = ~clk;

  irq_ctrl_top i_irq_ctrl_top (
    .clk(clk), .rst_n(rst_n), .irq_ext(src[6:0]), .irq_int(src[25:7]),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .crit_irq(crit_irq), .ncrit_irq(ncrit_irq), .crit_vector(crit_vector)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_req = 1'b0;
    chk(reg_rvalid === 1'b1, "R9 rvalid", 32'(reg_rvalid), 32'd1);
    d = reg_rdata;
  endtask

  task automatic set_rank(input int idx, input logic [3:0] v);
    rk[idx/8][(idx%8)*4 +: 4] = v;
    wr(4'(8 + idx/8), rk[idx/8]);
  endtask

  task automatic clean();
    src = '0;
    wr(4'd1, 32'h0);
    wr(4'd4, 32'h0);
    wr(4'd3, 32'h0);
    wr(4'd5, 32'h0);
    wr(4'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(crit_irq === 1'b0 && ncrit_irq === 1'b0, "R1 outputs", {crit_irq, ncrit_irq}, 32'd0);
    chk(crit_vector === 32'h0, "R1 vector", crit_vector, 32'h0);
    chk(reg_rvalid === 1'b0, "R1 rvalid", 32'(reg_rvalid), 32'd0);
    rd(4'd1, d); chk(d === 32'h0, "R1 enable", d, 32'h0);
    rd(4'd4, d); chk(d === 32'h0, "R1 trigger", d, 32'h0);
    rd(4'd7, d); chk(d === 32'h0, "R1 vec reg", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(4'd3, 32'h1 << 4);
    wr(4'd1, 32'h1 << 3);
    src[3] = 1'b1; src[5] = 1'b1;
    @(negedge clk);
    chk(ncrit_irq === 1'b1 && crit_irq === 1'b0, "R6 ncrit route", {crit_irq, ncrit_irq}, 32'd1);
    rd(4'd0, d);
    chk(d[5:3] === 3'b111, "R2 raw level/polarity", 32'(d[5:3]), 32'h7);
    rd(4'd2, d);
    chk(d[5:3] === 3'b001, "R5 masked", 32'(d[5:3]), 32'h1);
    src[3] = 1'b0;
    @(negedge clk);
    chk(ncrit_irq === 1'b0, "R5 disabled sources silent", 32'(ncrit_irq), 32'd0);
    rd(4'd0, d);
    chk(d[3] === 1'b0, "R2 level drops", 32'(d[3]), 32'd0);
    clean();
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(4'd4, (32'h1 << 10) | (32'h1 << 11) | (32'h1 << 12));
    wr(4'd3, 32'h1 << 11);
    wr(4'd5, (32'h1 << 10) | (32'h1 << 11) | (32'h1 << 12));
    wr(4'd1, 32'h1 << 10);
    src[10] = 1'b1;
    @(negedge clk);
    src[10] = 1'b0;
    @(negedge clk);
    chk(crit_irq === 1'b1, "R3 rising edge sticky", 32'(crit_irq), 32'd1);
    wr(4'd0, 32'h0);
    chk(crit_irq === 1'b1, "R4 zero write keeps", 32'(crit_irq), 32'd1);
    wr(4'd0, 32'h1 << 10);
    chk(crit_irq === 1'b0, "R4 write-one clears", 32'(crit_irq), 32'd0);
    wr(4'd1, 32'h1 << 11);
    src[11] = 1'b1;
    @(negedge clk);
    chk(crit_irq === 1'b0, "R3 rising ignored when active-low", 32'(crit_irq), 32'd0);
    src[11] = 1'b0;
    @(negedge clk);
    chk(crit_irq === 1'b1, "R3 falling edge captured", 32'(crit_irq), 32'd1);
    wr(4'd0, 32'h1 << 11);
    wr(4'd1, 32'h1 << 12);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h1 << 12;
    src[12] = 1'b1;
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0;
    rd(4'd0, d);
    chk(d[12] === 1'b1, "R4 set beats clear", 32'(d[12]), 32'd1);
    clean();
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(4'd6, 32'h0000_1000);
    set_rank(0, 4'd0);
    set_rank(2, 4'd5);
    set_rank(9, 4'd3);
    set_rank(20, 4'd3);
    wr(4'd5, (32'h1 << 2) | (32'h1 << 9) | (32'h1 << 20));
    wr(4'd1, 32'h1 | (32'h1 << 2) | (32'h1 << 9) | (32'h1 << 20));
    src[0] = 1'b1; src[2] = 1'b1; src[9] = 1'b1; src[20] = 1'b1;
    repeat (2) @(negedge clk);
    chk(crit_vector === 32'h1024, "R7 tie to lower index", crit_vector, 32'h1024);
    chk(crit_irq === 1'b1 && ncrit_irq === 1'b1, "R6 both outputs", {crit_irq, ncrit_irq}, 32'd3);
    rd(4'd7, d);
    chk(d === 32'h1024, "R8 vec register", d, 32'h1024);
    src[9] = 1'b0;
    repeat (2) @(negedge clk);
    chk(crit_vector === 32'h1050, "R7 next winner", crit_vector, 32'h1050);
    src[9] = 1'b1;
    set_rank(9, 4'd7);
    set_rank(20, 4'd9);
    @(negedge clk);
    chk(crit_vector === 32'h1008, "R7 rank beats index", crit_vector, 32'h1008);
    src[2] = 1'b0; src[9] = 1'b0; src[20] = 1'b0;
    repeat (2) @(negedge clk);
    chk(crit_vector === 32'h1000, "R8 idle is base", crit_vector, 32'h1000);
    chk(crit_irq === 1'b0, "R6 crit low", 32'(crit_irq), 32'd0);
    clean();
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(4'd3, 32'hFFAB_CDEF);
    rd(4'd3, d);
    chk(d === 32'h03AB_CDEF, "R9 polarity width", d, 32'h03AB_CDEF);
    wr(4'd3, 32'h0);
    wr(4'd6, 32'hDEAD_BEE0);
    rd(4'd6, d);
    chk(d === 32'hDEAD_BEE0, "R9 base readback", d, 32'hDEAD_BEE0);
    rk[1] = 32'h8765_4321;
    wr(4'd9, rk[1]);
    rd(4'd9, d);
    chk(d === 32'h8765_4321, "R9 rank word", d, 32'h8765_4321);
    rk[3] = 32'hFFFF_FFFF;
    wr(4'd11, rk[3]);
    rd(4'd11, d);
    chk(d === 32'h0000_00FF, "R9 last rank word width", d, 32'h0000_00FF);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, d);
    chk(d === 32'h0, "R9 masked read-only", d, 32'h0);
    rd(4'd12, d);
    chk(d === 32'h0, "R9 unmapped", d, 32'h0);
    @(negedge clk);
    chk(reg_rvalid === 1'b0, "R9 rvalid single", 32'(reg_rvalid), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) rk[i] = '0;
    @(negedge clk);
    t_reset();
    t_level();
    t_edge();
    t_prio();
    t_regs();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule